// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Status

This block holds the per-channel control/status words of a multi-channel peripheral DMA controller. Software reaches each channel's 32-bit word over a simple register bus: it sets the run, no-descriptor-fetch and stop-interrupt-enable controls, reads live state flags, and clears sticky event flags by writing back the value it has just read. The channel engines report transfer start, transfer end, stop reached and bus error as single-cycle pulses, and each engine gets its run enable back from this block.

A summary register carries one pending bit per channel. A channel is pending when a set event flag meets its enable: the end flag is enabled by the current descriptor's end-interrupt bit, the start flag by the descriptor's start-interrupt bit, the stop state by the stop-interrupt enable, and a bus error always counts. The OR of all summary bits drives one combined interrupt line. A separate alignment register holds one bit per channel, allowing that channel to use addresses that are not 8-byte aligned.

Top module: `dma_csr_top`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stop-state bit 3 set), every run enable is 0, the summary and alignment registers read 0 and the interrupt line is low.
- R2: Bits 31 (run), 30 (no-descriptor-fetch) and 29 (stop-interrupt enable) of a channel word are read/write; all bits other than 31, 30, 29, 8, 3, 2, 1, 0 read 0.
- R3: Bit 2 (end), bit 1 (start) and bit 0 (bus error) are set by the matching event pulse and stay set until a write with a 1 in that bit; a 0 written there leaves the flag unchanged, so writing back a value just read clears exactly the flags that were set.
- R4: An event pulse in the same cycle as a write clearing its flag leaves the flag set.
- R5: Bit 8 of channel n reads the live request-pending input of channel n.
- R6: Bit 3 (stop state) is set by a stop or bus-error pulse, which also clears run; a write that sets run while run is 0 clears the stop state.
- R7: The run enable of channel n equals bit 31 of channel n's word, changing the cycle after the write or event that changes it.
- R8: The summary register at byte offset SUM_OFS has bit n = (end AND descriptor end-enable) OR (start AND descriptor start-enable) OR (stop state AND stop-interrupt enable) OR bus error of channel n; upper bits read 0 and writes to it have no effect.
- R9: The interrupt output is high exactly when any summary bit is set; a bus error raises it in the next cycle regardless of enables.
- R10: The alignment register at byte offset ALN_OFS holds NUM_CH read/write bits, bit n for channel n; upper bits read 0.
- R11: Channel n's word sits at byte offset 4*n; any other offset, including misaligned ones, reads 0 and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| ev_start | input | NUM_CH | Transfer-start pulse per channel |
| ev_end | input | NUM_CH | Transfer-end pulse per channel |
| ev_stop | input | NUM_CH | Stop-reached pulse per channel |
| ev_buserr | input | NUM_CH | Bus-error pulse per channel |
| req_pend | input | NUM_CH | Live request-pending level per channel |
| desc_start_ie | input | NUM_CH | Current descriptor start-interrupt enable |
| desc_end_ie | input | NUM_CH | Current descriptor end-interrupt enable |
| run_en | output | NUM_CH | Run enable to each channel engine |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit address, the summary at 0x40 and the alignment register at 0x44. Four channels are enough to place distinct control patterns on every channel at once and to see each source of a summary bit on a different channel, while offset 0x10 just above the last channel and misaligned offsets fall into the unmapped space. The narrow alignment register makes the read-as-zero upper bits visible with an all-ones write.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int BIT_RUN     = 31;
    localparam int BIT_NOFETCH = 30;
    localparam int BIT_STOPIE  = 29;
    localparam int BIT_REQ     = 8;
    localparam int BIT_STOPPED = 3;
    localparam int BIT_END     = 2;
    localparam int BIT_START   = 1;
    localparam int BIT_ERR     = 0;

    typedef struct packed {
        logic run;
        logic nofetch;
        logic stop_ie;
        logic stopped;
        logic end_f;
        logic start_f;
        logic err_f;
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '{run: 1'b0, nofetch: 1'b0, stop_ie: 1'b0,
                                           stopped: 1'b1, end_f: 1'b0,
                                           start_f: 1'b0, err_f: 1'b0};

endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
    import dma_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic        w_run,
    input  logic        w_nofetch,
    input  logic        w_stopie,
    input  logic [2:0]  w_clr,
    input  logic        ev_start,
    input  logic        ev_end,
    input  logic        ev_stop,
    input  logic        ev_buserr,
    input  logic        req_pend,
    input  logic        desc_start_ie,
    input  logic        desc_end_ie,
    output logic [31:0] csr_word,
    output logic        run,
    output logic        pend
);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.run     = w_run;
            st_d.nofetch = w_nofetch;
            st_d.stop_ie = w_stopie;
            if (w_run && !st_q.run) begin
                st_d.stopped = 1'b0;
            end
            st_d.end_f   = st_q.end_f   & ~w_clr[BIT_END];
            st_d.start_f = st_q.start_f & ~w_clr[BIT_START];
            st_d.err_f   = st_q.err_f   & ~w_clr[BIT_ERR];
        end
        st_d.end_f   = st_d.end_f   | ev_end;
        st_d.start_f = st_d.start_f | ev_start;
        st_d.err_f   = st_d.err_f   | ev_buserr;
        if (ev_stop || ev_buserr) begin
            st_d.run     = 1'b0;
            st_d.stopped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHAN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_word              = '0;
        csr_word[BIT_RUN]     = st_q.run;
        csr_word[BIT_NOFETCH] = st_q.nofetch;
        csr_word[BIT_STOPIE]  = st_q.stop_ie;
        csr_word[BIT_REQ]     = req_pend;
        csr_word[BIT_STOPPED] = st_q.stopped;
        csr_word[BIT_END]     = st_q.end_f;
        csr_word[BIT_START]   = st_q.start_f;
        csr_word[BIT_ERR]     = st_q.err_f;
    end

    assign run  = st_q.run;
    assign pend = (st_q.end_f & desc_end_ie) | (st_q.start_f & desc_start_ie)
                | (st_q.stopped & st_q.stop_ie) | st_q.err_f;

endmodule

// File: rtl/dma_csr_align.sv
module dma_csr_align #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [NUM_CH-1:0] w_bits,
    output logic [NUM_CH-1:0] bits
);

    logic [NUM_CH-1:0] aln_d, aln_q;

    always_comb begin
        aln_d = aln_q;
        if (wr_hit) begin
            aln_d = w_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aln_q <= '0;
        end else begin
            aln_q <= aln_d;
        end
    end

    assign bits = aln_q;

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int              NUM_CH  = 4,
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SUM_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] ALN_OFS = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_stop,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] req_pend,
    input  logic [NUM_CH-1:0] desc_start_ie,
    input  logic [NUM_CH-1:0] desc_end_ie,
    output logic [NUM_CH-1:0] run_en,
    output logic              irq
);

    localparam int SUM_W = NUM_CH;

    logic [31:0]       word_arr [NUM_CH];
    logic [SUM_W-1:0]  sum_vec;
    logic [NUM_CH-1:0] aln_bits;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        dma_csr_chan u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_hit        (wr_en && (addr == ADDR_W'(4 * i))),
            .w_run         (wdata[BIT_RUN]),
            .w_nofetch     (wdata[BIT_NOFETCH]),
            .w_stopie      (wdata[BIT_STOPIE]),
            .w_clr         (wdata[2:0]),
            .ev_start      (ev_start[i]),
            .ev_end        (ev_end[i]),
            .ev_stop       (ev_stop[i]),
            .ev_buserr     (ev_buserr[i]),
            .req_pend      (req_pend[i]),
            .desc_start_ie (desc_start_ie[i]),
            .desc_end_ie   (desc_end_ie[i]),
            .csr_word      (word_arr[i]),
            .run           (run_en[i]),
            .pend          (sum_vec[i])
        );
    end

    dma_csr_align #(.NUM_CH(NUM_CH)) u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_en && (addr == ALN_OFS)),
        .w_bits (wdata[NUM_CH-1:0]),
        .bits   (aln_bits)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(4 * i)) begin
                rdata = word_arr[i];
            end
        end
        if (addr == SUM_OFS) begin
            rdata = 32'(sum_vec);
        end
        if (addr == ALN_OFS) begin
            rdata = 32'(aln_bits);
        end
    end

    assign irq = |sum_vec;

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NUM_CH-1:0] ev_stop,
    input logic [NUM_CH-1:0] ev_buserr,
    input logic [NUM_CH-1:0] req_pend,
    input logic [NUM_CH-1:0] run_en,
    input logic              irq
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(4 * i);

        p_stop_clears_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_stop[i] || ev_buserr[i]) |=> !run_en[i]);

        p_run_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CA && !ev_stop[i] && !ev_buserr[i])
            |=> run_en[i] == $past(wdata[31]));

        p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && addr == CA) && !ev_stop[i] && !ev_buserr[i])
            |=> $stable(run_en[i]));

        p_req_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == CA) |-> rdata[8] == req_pend[i]);

        p_buserr_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ev_buserr[i] |=> irq);
    end

    p_misaligned_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00 && !(|ev_stop) && !(|ev_buserr))
        |=> $stable(run_en));

endmodule

bind dma_csr_top dma_csr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ev_stop   (ev_stop),
    .ev_buserr (ev_buserr),
    .req_pend  (req_pend),
    .run_en    (run_en),
    .irq       (irq)
);

// File: tb/sim_dma_csr_top.sv
`timescale 1ns/1ps
module sim_dma_csr_top;

    localparam int NCH = 4;
    localparam logic [7:0] SUM_A = 8'h40;
    localparam logic [7:0] ALN_A = 8'h44;

    localparam int N_VEC = 6;
    localparam int          VEC_CH  [N_VEC] = '{0, 1, 2, 2, 3, 3};
    localparam logic [31:0] VEC_WR  [N_VEC] = '{32'h4000_0000, 32'h2000_0000, 32'hE000_0000,
                                                32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000};
    localparam logic [31:0] VEC_EXP [N_VEC] = '{32'h4000_0008, 32'h2000_0008, 32'hE000_0000,
                                                32'h0000_0000, 32'hE000_0000, 32'h8000_0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_stop = '0, ev_buserr = '0;
    logic [NCH-1:0] req_pend = '0, desc_start_ie = '0, desc_end_ie = '0;
    logic [NCH-1:0] run_en;
    logic irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    dma_csr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ev_start(ev_start), .ev_end(ev_end), .ev_stop(ev_stop), .ev_buserr(ev_buserr),
        .req_pend(req_pend), .desc_start_ie(desc_start_ie), .desc_end_ie(desc_end_ie),
        .run_en(run_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    // kind: 0 start, 1 end, 2 stop, 3 bus error
    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        case (kind)
            0: ev_start[ch]  = 1'b1;
            1: ev_end[ch]    = 1'b1;
            2: ev_stop[ch]   = 1'b1;
            default: ev_buserr[ch] = 1'b1;
        endcase
        @(negedge clk);
        ev_start = '0; ev_end = '0; ev_stop = '0; ev_buserr = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R2 / R7: table of control writes and expected words
        for (int k = 0; k < N_VEC; k++) begin
            bus_write(8'(4 * VEC_CH[k]), VEC_WR[k]);
            bus_read(8'(4 * VEC_CH[k]), rv);
            check($sformatf("R2 vec%0d word", k), rv, VEC_EXP[k]);
            check($sformatf("R7 vec%0d run_en", k), 32'(run_en[VEC_CH[k]]), 32'(VEC_EXP[k][31]));
        end

        // R1: reset state
        do_reset();
        for (int c = 0; c < NCH; c++) begin
            bus_read(8'(4 * c), rv);
            check("R1 word after reset", rv, 32'h0000_0008);
        end
        bus_read(SUM_A, rv);
        check("R1 summary", rv, 32'h0);
        bus_read(ALN_A, rv);
        check("R1 align", rv, 32'h0);
        check("R1 run_en", 32'(run_en), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R3: sticky flags, write-zero keeps, write-back clears
        pulse(1, 0);
        bus_read(8'h00, rv);
        check("R3 end flag set", rv, 32'h0000_000C);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, rv);
        check("R3 write zero keeps", rv, 32'h0000_000C);
        bus_write(8'h00, 32'h4);
        bus_read(8'h00, rv);
        check("R3 end cleared", rv, 32'h0000_0008);
        pulse(0, 0);
        pulse(3, 0);
        bus_read(8'h00, rv);
        check("R3 start+err set", rv, 32'h0000_000B);
        bus_write(8'h00, rv);
        bus_read(8'h00, rv);
        check("R3 write-back clears", rv, 32'h0000_0008);

        // R8 / R9: summary sources
        pulse(1, 1);
        bus_read(SUM_A, rv);
        check("R8 end without enable", rv, 32'h0);
        check("R9 irq low", 32'(irq), 32'h0);
        desc_end_ie[1] = 1'b1;
        bus_read(SUM_A, rv);
        check("R8 end with enable", rv, 32'h2);
        check("R9 irq high", 32'(irq), 32'h1);
        bus_write(8'h04, 32'h4);
        bus_read(SUM_A, rv);
        check("R8 end cleared", rv, 32'h0);
        desc_end_ie[1] = 1'b0;
        pulse(3, 2);
        bus_read(SUM_A, rv);
        check("R8 bus error always", rv, 32'h4);
        check("R9 irq on bus error", 32'(irq), 32'h1);
        bus_write(8'h08, 32'h1);
        bus_write(8'h0C, 32'h2000_0000);
        bus_read(SUM_A, rv);
        check("R8 stop state with enable", rv, 32'h8);
        bus_write(SUM_A, 32'h0);
        bus_read(SUM_A, rv);
        check("R8 summary write ignored", rv, 32'h8);
        bus_write(8'h0C, 32'h0);
        bus_read(SUM_A, rv);
        check("R8 summary clear", rv, 32'h0);
        check("R9 irq cleared", 32'(irq), 32'h0);

        // R6: stop and bus error halt the channel
        bus_write(8'h00, 32'h8000_0000);
        bus_read(8'h00, rv);
        check("R6 run clears stop state", rv, 32'h8000_0000);
        check("R7 run_en set", 32'(run_en[0]), 32'h1);
        pulse(2, 0);
        bus_read(8'h00, rv);
        check("R6 stop pulse", rv, 32'h0000_0008);
        check("R7 run_en cleared", 32'(run_en[0]), 32'h0);
        bus_write(8'h00, 32'h8000_0000);
        pulse(3, 0);
        bus_read(8'h00, rv);
        check("R6 bus error halts", rv, 32'h0000_0009);
        check("R6 run_en after error", 32'(run_en[0]), 32'h0);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, rv);
        check("R6 error cleared", rv, 32'h0000_0008);

        // R4: event wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h04; wdata = 32'h4; ev_end[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ev_end = '0;
        bus_read(8'h04, rv);
        check("R4 event beats clear", rv, 32'h0000_000C);
        bus_write(8'h04, 32'h4);

        // R5: request pending is live
        req_pend[2] = 1'b1;
        bus_read(8'h08, rv);
        check("R5 req pending", rv, 32'h0000_0108);
        req_pend[2] = 1'b0;
        bus_read(8'h08, rv);
        check("R5 req released", rv, 32'h0000_0008);

        // R10: alignment register
        bus_write(ALN_A, 32'hFFFF_FFFF);
        bus_read(ALN_A, rv);
        check("R10 align all ones", rv, 32'h0000_000F);
        bus_write(ALN_A, 32'h5);
        bus_read(ALN_A, rv);
        check("R10 align pattern", rv, 32'h0000_0005);

        // R11: unmapped and misaligned offsets
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h02, 32'hFFFF_FFFF);
        bus_read(8'h10, rv);
        check("R11 unmapped reads zero", rv, 32'h0);
        bus_read(8'h02, rv);
        check("R11 misaligned reads zero", rv, 32'h0);
        bus_read(8'h00, rv);
        check("R11 ch0 untouched", rv, 32'h0000_0008);
        check("R11 run_en untouched", 32'(run_en), 32'h0);
        check("R11 irq untouched", 32'(irq), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule